// File: doc/BRIEF.md
# Asynchronous Serial Adapter

This block connects a byte-wide host bus to a pair of asynchronous serial lines. The host writes a control byte and reads a status byte at one register-select level. At the other level it writes characters to transmit and reads characters that have been received. The transmitter frames each character with a start bit, seven or eight data bits, an optional parity bit and one or two stop bits. The receiver finds the start bit, samples every bit and reports parity, framing and overrun faults.

Bit timing comes from an external bit-clock enable, `bit_tick`, which is divided by 1, 16 or 64. The adapter drives an active-low interrupt request and an active-low ready-to-send output. It watches two modem inputs, clear-to-send and carrier-detect, and reflects them in status. After power-up the adapter sits in master reset. It stays there until software writes a control byte whose divide field is not 11.

The serial input `rxd` is assumed to be synchronous to `clk`. The divided bit period is counted in `bit_tick` pulses.

Top module: `sio_adapter`

## Requirements
- R1: After `rst_n`, and after any control write whose bits 1:0 are 11, the adapter is in master reset. In master reset, status reads 0x00 when `cts_n` and `dcd_n` are low, `txd`, `irq_n` and `rts_n` are high, and transmit data writes are ignored. A control write whose bits 1:0 are not 11 leaves master reset and stores the byte.
- R2: An access with `acc` high takes effect only when `cs_hi0` and `cs_hi1` are high and `cs_lo_n` is low. With `rs`=0, a write (`rw`=0) goes to control and a read (`rw`=1) returns status. With `rs`=1, a write goes to transmit data and a read returns receive data. An access while unselected changes nothing.
- R3: Control bits 4:2 pick the frame.
  - 000 is 7 data bits, even parity, 2 stop bits.
  - 001 is 7 data bits, odd parity, 2 stop bits.
  - 010 is 7 data bits, even parity, 1 stop bit.
  - 011 is 7 data bits, odd parity, 1 stop bit.
  - 100 is 8 data bits, no parity, 2 stop bits.
  - 101 is 8 data bits, no parity, 1 stop bit.
  - 110 is 8 data bits, even parity, 1 stop bit.
  - 111 is 8 data bits, odd parity, 1 stop bit.

  `txd` sends a 0 start bit, then the data LSB first, then the parity bit if any, then the stop bits at 1. Data bit 7 is not sent in 7-bit formats.
- R4: Control bits 1:0 set the bit length: 00 is 1 `bit_tick` pulse, 01 is 16 pulses and 10 is 64 pulses. At 16 and 64 the receiver samples near the middle of each bit. At 1 it samples on every pulse.
- R5: A received character is placed in the receive data register and sets status bit 0. In 7-bit formats, read data bit 7 is 0. Reading receive data clears status bits 0, 4, 5 and 6.
- R6: Status bit 6 is set when the received parity is wrong. Status bit 4 is set when the first stop bit is received as 0.
- R7: If a character completes while status bit 0 is set, status bit 5 is set and the held character is kept.
- R8: Status bit 1 is transmit-data empty. A transmit data write clears it, and it sets again when the byte moves into the shifter. Status bit 3 follows `cts_n`. While `cts_n` is high, bit 1 reads 0 and no new frame starts.
- R9: Control bits 6:5 set the transmitter mode.
  - 00: `rts_n` is low and the transmit interrupt is off.
  - 01: `rts_n` is low and the transmit interrupt is on, so `irq_n` is low while bit 1 is set.
  - 10: `rts_n` is high.
  - 11: `rts_n` is low and `txd` is held at 0 (break).
- R10: Control bit 7 enables the receive interrupt. When enabled, `irq_n` is low while status bit 0, bit 5 or bit 2 is set. Status bit 7 reads 1 exactly while `irq_n` is low.
- R11: A low-to-high transition of `dcd_n` sets status bit 2. The bit clears only when a status read is followed by a receive data read. A data read without a prior status read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; enters master reset |
| bit_tick | input | 1 | One-cycle bit-clock enable, divided by the selected ratio |
| acc | input | 1 | Bus access strobe, one cycle per access |
| cs_hi0 | input | 1 | Chip select, active high |
| cs_hi1 | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 control/status, 1 data |
| rw | input | 1 | 1 read, 0 write |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data to the host (status or receive data) |
| irq_n | output | 1 | Interrupt request, active low |
| rts_n | output | 1 | Ready-to-send, active low |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |

## Verification
The hardest state to reach is the carrier-loss bit being released. It needs `dcd_n` to rise, then a data read that must not release it, then a status read, then a second data read that must. The stimulus drives that exact order and checks the bit between each step.

Overrun is reached by sending two whole frames into the receiver without reading it. A held transmit byte is reached by raising `cts_n` before the write, watching `txd` stay idle, and then capturing the frame that starts once `cts_n` falls.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
    localparam int FRAME_W = 12;   // start + 8 data + parity + 2 stop
    localparam int CNT_W   = 6;    // holds divide-by-64 terminal count

    typedef struct packed {
        logic [3:0] ndata;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } fmt_t;

    function automatic fmt_t decode_fmt(input logic [2:0] w);
        fmt_t f;
        f.ndata    = w[2] ? 4'd8 : 4'd7;
        f.par_en   = !(w[2] && !w[1]);
        f.par_odd  = w[0];
        f.two_stop = (w == 3'b000) || (w == 3'b001) || (w == 3'b100);
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] div_last(input logic [1:0] sel);
        case (sel)
            2'b01:   return CNT_W'(15);
            2'b10:   return CNT_W'(63);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] div_max,
    input  fmt_t             fmt,
    input  logic             load,
    input  logic [7:0]       ldata,
    output logic             busy,
    output logic             txd_raw
);
    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         left;
        logic [CNT_W-1:0]   cnt;
    } tx_t;

    tx_t q, d;
    logic [FRAME_W-1:0] frame;
    logic               par;

    always_comb begin
        par   = fmt.par_odd;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (4'(i) < fmt.ndata) begin
                frame[1+i] = ldata[i];
                par        = par ^ ldata[i];
            end
        end
        if (fmt.par_en) frame[4'd1 + fmt.ndata] = par;
    end

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (load && !q.busy) begin
            d.busy = 1'b1;
            d.sh   = frame;
            d.cnt  = '0;
            d.left = 4'd2 + fmt.ndata + {3'b0, fmt.par_en} + {3'b0, fmt.two_stop};
        end else if (q.busy && tick) begin
            if (q.cnt == div_max) begin
                d.cnt  = '0;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                d.left = q.left - 4'd1;
                if (q.left == 4'd1) d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign txd_raw = q.busy ? q.sh[0] : 1'b1;

    // R3
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) && !$past(clear) |-> $past(txd_raw));
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] div_max,
    input  fmt_t             fmt,
    input  logic             rxd,
    output logic             done,
    output logic [7:0]       dout,
    output logic             perr,
    output logic             ferr
);
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

    typedef struct packed {
        rx_st_e           st;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       idx;
        logic [7:0]       sh;
        logic             acc;
        logic             done;
        logic             perr;
        logic             ferr;
    } rx_t;

    rx_t q, d;
    logic [3:0]       stop_idx;
    logic [CNT_W-1:0] half;

    assign stop_idx = fmt.ndata + {3'b0, fmt.par_en};
    assign half     = {1'b0, div_max[CNT_W-1:1]};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (clear) begin
            d = '0;
        end else if (tick) begin
            case (q.st)
                RX_IDLE: if (!rxd) begin
                    d.cnt = '0;
                    d.idx = '0;
                    d.sh  = '0;
                    d.acc = 1'b0;
                    d.st  = (div_max == '0) ? RX_BITS : RX_START;
                end
                RX_START: if (q.cnt == half) begin
                    d.cnt = '0;
                    d.st  = rxd ? RX_IDLE : RX_BITS;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
                RX_BITS: if (q.cnt != div_max) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end else begin
                    d.cnt = '0;
                    d.idx = q.idx + 4'd1;
                    if (q.idx < fmt.ndata) begin
                        d.sh[q.idx[2:0]] = rxd;
                        d.acc = q.acc ^ rxd;
                    end else if (q.idx < stop_idx) begin
                        d.acc = q.acc ^ rxd;
                    end else begin
                        d.done = 1'b1;
                        d.ferr = !rxd;
                        d.perr = fmt.par_en && (q.acc != fmt.par_odd);
                        d.st   = RX_IDLE;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign dout = q.sh;
    assign perr = q.perr;
    assign ferr = q.ferr;

    // R4
    start_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == RX_START && !tick && !clear |=> $stable(q.cnt));
endmodule

// File: rtl/sio_adapter.sv
`timescale 1ns/1ps
module sio_adapter
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       acc,
    input  logic       cs_hi0,
    input  logic       cs_hi1,
    input  logic       cs_lo_n,
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_n,
    output logic       rts_n,
    output logic       txd,
    input  logic       rxd,
    input  logic       cts_n,
    input  logic       dcd_n
);
    typedef struct packed {
        logic       mres;
        logic [7:0] ctl;
        logic [7:0] tdr;
        logic       tfull;
        logic [7:0] rdr;
        logic       rfull;
        logic       ovrn;
        logic       fe;
        logic       pe;
        logic       dlost;
        logic       darm;
        logic       dprev;
    } reg_t;

    reg_t q, d;

    logic             sel, wr_ctl, rd_st, wr_tdr, rd_rdr;
    logic             tx_busy, tx_load, tx_bit;
    logic             rx_done, rx_perr, rx_ferr;
    logic [7:0]       rx_data;
    logic [CNT_W-1:0] div_max;
    fmt_t             fmt;
    logic             tdre, irq, tx_ie, brk;
    logic [7:0]       status;

    assign sel    = acc && cs_hi0 && cs_hi1 && !cs_lo_n;
    assign wr_ctl = sel && !rs && !rw;
    assign rd_st  = sel && !rs &&  rw;
    assign wr_tdr = sel &&  rs && !rw;
    assign rd_rdr = sel &&  rs &&  rw;

    assign div_max = div_last(q.ctl[1:0]);
    assign fmt     = decode_fmt(q.ctl[4:2]);
    assign tx_load = q.tfull && !tx_busy && !cts_n && !q.mres;

    assign tdre  = !q.tfull && !cts_n && !q.mres;
    assign tx_ie = (q.ctl[6:5] == 2'b01);
    assign brk   = (q.ctl[6:5] == 2'b11) && !q.mres;
    assign irq   = !q.mres && ((q.ctl[7] && (q.rfull || q.ovrn || q.dlost)) || (tx_ie && tdre));
    assign status = {irq, q.pe, q.ovrn, q.fe, cts_n, q.dlost, tdre, q.rfull};

    assign rdata = rs ? q.rdr : status;
    assign irq_n = !irq;
    assign rts_n = q.mres || (q.ctl[6:5] == 2'b10);
    assign txd   = q.mres ? 1'b1 : (brk ? 1'b0 : tx_bit);

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .clear(q.mres), .tick(bit_tick),
        .div_max(div_max), .fmt(fmt), .load(tx_load), .ldata(q.tdr),
        .busy(tx_busy), .txd_raw(tx_bit)
    );

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .clear(q.mres), .tick(bit_tick),
        .div_max(div_max), .fmt(fmt), .rxd(rxd),
        .done(rx_done), .dout(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_comb begin
        d       = q;
        d.dprev = dcd_n;
        if (tx_load) d.tfull = 1'b0;
        if (wr_tdr && !q.mres) begin
            d.tdr   = wdata;
            d.tfull = 1'b1;
        end
        if (rd_rdr) begin
            d.rfull = 1'b0;
            d.ovrn  = 1'b0;
            d.fe    = 1'b0;
            d.pe    = 1'b0;
            if (q.darm) begin
                d.dlost = 1'b0;
                d.darm  = 1'b0;
            end
        end
        if (rd_st && q.dlost) d.darm = 1'b1;
        if (rx_done) begin
            if (d.rfull) begin
                d.ovrn = 1'b1;
            end else begin
                d.rdr   = rx_data;
                d.rfull = 1'b1;
                d.fe    = rx_ferr;
                d.pe    = rx_perr;
            end
        end
        if (dcd_n && !q.dprev) begin
            d.dlost = 1'b1;
            d.darm  = 1'b0;
        end
        if (wr_ctl) begin
            if (&wdata[1:0]) begin
                d.mres = 1'b1;
            end else begin
                d.mres = 1'b0;
                d.ctl  = wdata;
            end
        end
        if (d.mres) begin
            d.tfull = 1'b0;
            d.rfull = 1'b0;
            d.ovrn  = 1'b0;
            d.fe    = 1'b0;
            d.pe    = 1'b0;
            d.dlost = 1'b0;
            d.darm  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.mres  <= 1'b1;
            q.dprev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R1
    mreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && (&wdata[1:0]) |=> irq_n && !q.rfull && txd);
    // R7
    ovrn_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovrn) |-> $stable(q.rdr));
    // R5
    rd_clears_ovrn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rdr |=> !q.ovrn);
    // R8
    tdre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tdr && !q.mres |=> !status[1]);
    // R11
    dcd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dcd_n) && !q.mres && !wr_ctl |=> status[2]);
endmodule

// File: tb/sio_adapter_tb.sv
`timescale 1ns/1ps
module sio_adapter_tb;
    logic       clk = 0, rst_n = 0, bit_tick = 0, acc = 0;
    logic       cs_hi0 = 1, cs_hi1 = 1, cs_lo_n = 0, rs = 0, rw = 1;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq_n, rts_n, txd;
    logic       rxd = 1, cts_n = 0, dcd_n = 0;
    int         checks = 0, errors = 0;

    sio_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .acc(acc),
        .cs_hi0(cs_hi0), .cs_hi1(cs_hi1), .cs_lo_n(cs_lo_n), .rs(rs), .rw(rw),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .rts_n(rts_n), .txd(txd),
        .rxd(rxd), .cts_n(cts_n), .dcd_n(dcd_n)
    );

    always #2.5 clk = ~clk;
    always @(negedge clk) bit_tick <= ~bit_tick;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctlv(input bit rie, input logic [1:0] txc,
                                        input logic [2:0] f, input logic [1:0] dv);
        return {rie, txc, f, dv};
    endfunction

    function automatic int build_frame(input logic [2:0] f, input logic [7:0] dat, input bit bad_par,
                                       input bit bad_stop, output logic [11:0] bits);
        int  nd   = f[2] ? 8 : 7;
        bit  pen  = !(f == 3'd4 || f == 3'd5);
        bit  two  = (f == 3'd0 || f == 3'd1 || f == 3'd4);
        bit  p    = f[0];
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            bits[1+i] = dat[i];
            p = p ^ dat[i];
        end
        if (pen) bits[1+nd] = p ^ bad_par;
        if (bad_stop) bits[1+nd+int'(pen)] = 1'b0;
        return 2 + nd + int'(pen) + int'(two);
    endfunction

    task automatic bwr(input bit r, input logic [7:0] v);
        @(negedge clk);
        rs = r; rw = 0; wdata = v; acc = 1;
        @(negedge clk);
        acc = 0; rw = 1;
    endtask

    task automatic brd(input bit r, output logic [7:0] v);
        @(negedge clk);
        rs = r; rw = 1; acc = 1;
        #1 v = rdata;
        @(negedge clk);
        acc = 0;
    endtask

    task automatic send_rx(input logic [2:0] f, input int ratio, input logic [7:0] dat,
                           input bit bp, input bit bs);
        logic [11:0] bits;
        int len = build_frame(f, dat, bp, bs, bits);
        @(negedge clk);
        for (int k = 0; k < len; k++) begin
            rxd = bits[k];
            repeat (2*ratio) @(negedge clk);
        end
        rxd = 1;
        repeat (4*ratio + 4) @(negedge clk);
    endtask

    task automatic capture_tx(input logic [2:0] f, input int ratio, input logic [7:0] dat,
                              input string tag);
        logic [11:0] exp_bits, got;
        int len = build_frame(f, dat, 0, 0, exp_bits);
        int t = 0;
        got = '1;
        while (txd !== 1'b0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 20000) begin
            chk({tag, " start bit seen"}, 0, 1);
        end else begin
            repeat (ratio) @(negedge clk);
            got[0] = txd;
            for (int k = 1; k < len; k++) begin
                repeat (2*ratio) @(negedge clk);
                got[k] = txd;
            end
            chk(tag, 32'(got & 12'((1 << len) - 1)), 32'(exp_bits & 12'((1 << len) - 1)));
            repeat (2*ratio + 2) @(negedge clk);
        end
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, d1, d2;
        bit lowseen;
        v = 8'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        brd(0, v);  chk("R1 status after reset", v, 8'h00);
        chk("R1 txd idle", txd, 1);
        chk("R1 irq_n high", irq_n, 1);
        chk("R1 rts_n high", rts_n, 1);
        bwr(1, 8'h5a);
        brd(0, v);  chk("R1 tx write ignored in reset", v, 8'h00);

        // R2 unselected access ignored
        cs_lo_n = 1;
        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b00));
        cs_lo_n = 0;
        chk("R2 unselected ctl write ignored", rts_n, 1);
        cs_hi1 = 0;
        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b00));
        cs_hi1 = 1;
        brd(0, v);  chk("R2 low cs_hi1 ignored", v, 8'h00);

        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b00));
        brd(0, v);  chk("R8 tdre after leaving reset", v, 8'h02);
        chk("R9 rts_n low in mode 00", rts_n, 0);

        // R3 all frame formats, divide by 1
        for (int f = 0; f < 8; f++) begin
            bwr(0, ctlv(0, 2'b00, 3'(f), 2'b00));
            d1 = 8'($urandom) | 8'h80;
            bwr(1, d1);
            capture_tx(3'(f), 1, d1, $sformatf("R3 tx frame fmt %0d", f));
        end

        // R4 divide by 16 and 64 on transmit
        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b01));
        d1 = 8'($urandom);
        bwr(1, d1);
        capture_tx(3'd5, 16, d1, "R4 tx divide 16");
        bwr(0, ctlv(0, 2'b00, 3'd7, 2'b10));
        d1 = 8'($urandom);
        bwr(1, d1);
        capture_tx(3'd7, 64, d1, "R4 tx divide 64");

        // R5 receive all formats, divide by 1
        for (int f = 0; f < 8; f++) begin
            bwr(0, ctlv(0, 2'b00, 3'(f), 2'b00));
            d1 = 8'($urandom);
            send_rx(3'(f), 1, d1, 0, 0);
            brd(0, v);  chk($sformatf("R5 rx full fmt %0d", f), v, 8'h03);
            brd(1, v);  chk($sformatf("R5 rx data fmt %0d", f), v, f < 4 ? {1'b0, d1[6:0]} : d1);
            brd(0, v);  chk($sformatf("R5 rx cleared fmt %0d", f), v, 8'h02);
        end

        // R4 receive at 16 and 64
        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b01));
        d1 = 8'($urandom);
        send_rx(3'd5, 16, d1, 0, 0);
        brd(1, v);  chk("R4 rx divide 16", v, d1);
        bwr(0, ctlv(0, 2'b00, 3'd3, 2'b10));
        d1 = 8'($urandom);
        send_rx(3'd3, 64, d1, 0, 0);
        brd(1, v);  chk("R4 rx divide 64", v, {1'b0, d1[6:0]});

        // R6 parity and framing errors
        bwr(0, ctlv(0, 2'b00, 3'd2, 2'b00));
        send_rx(3'd2, 1, 8'h35, 1, 0);
        brd(0, v);  chk("R6 parity error", v, 8'h43);
        brd(1, v);
        brd(0, v);  chk("R5 read clears parity error", v, 8'h02);
        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b00));
        send_rx(3'd5, 1, 8'hc4, 0, 1);
        brd(0, v);  chk("R6 framing error", v, 8'h13);
        brd(1, v);  chk("R6 data with framing error", v, 8'hc4);
        brd(0, v);  chk("R5 read clears framing error", v, 8'h02);

        // R7 overrun
        d1 = 8'($urandom); d2 = ~d1;
        send_rx(3'd5, 1, d1, 0, 0);
        send_rx(3'd5, 1, d2, 0, 0);
        brd(0, v);  chk("R7 overrun flag", v, 8'h23);
        brd(1, v);  chk("R7 first byte kept", v, d1);
        brd(0, v);  chk("R7 overrun cleared by read", v, 8'h02);

        // R8 clear-to-send gating
        cts_n = 1;
        brd(0, v);  chk("R8 cts high status", v, 8'h08);
        d1 = 8'($urandom);
        bwr(1, d1);
        lowseen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lowseen = 1;
        end
        chk("R8 no frame while cts high", lowseen, 0);
        cts_n = 0;
        capture_tx(3'd5, 1, d1, "R8 frame after cts low");

        // R9 transmitter modes
        bwr(0, ctlv(0, 2'b10, 3'd5, 2'b00));
        chk("R9 rts_n high in mode 10", rts_n, 1);
        chk("R9 no irq in mode 10", irq_n, 1);
        bwr(0, ctlv(0, 2'b01, 3'd5, 2'b00));
        chk("R9 tx irq in mode 01", irq_n, 0);
        brd(0, v);  chk("R10 status irq bit", v, 8'h82);
        bwr(0, ctlv(0, 2'b11, 3'd5, 2'b00));
        repeat (3) @(negedge clk);
        chk("R9 break drives txd low", txd, 0);
        chk("R9 rts_n low in break", rts_n, 0);
        bwr(0, ctlv(0, 2'b00, 3'd5, 2'b00));
        chk("R9 txd idle after break", txd, 1);

        // R10 receive interrupt
        bwr(0, ctlv(1, 2'b00, 3'd5, 2'b00));
        chk("R10 no irq while empty", irq_n, 1);
        d1 = 8'($urandom);
        send_rx(3'd5, 1, d1, 0, 0);
        chk("R10 irq on rx full", irq_n, 0);
        brd(0, v);  chk("R10 status with irq", v, 8'h83);
        brd(1, v);
        chk("R10 irq released by read", irq_n, 1);

        // R11 carrier loss latch and release order
        dcd_n = 1;
        repeat (3) @(negedge clk);
        chk("R11 irq on carrier loss", irq_n, 0);
        dcd_n = 0;
        brd(1, v);
        brd(0, v);  chk("R11 kept after data read alone", v, 8'h86);
        brd(1, v);
        brd(0, v);  chk("R11 released after status then data", v, 8'h02);
        chk("R11 irq released", irq_n, 1);

        // R1 software master reset
        send_rx(3'd5, 1, 8'h77, 0, 0);
        bwr(0, 8'h03);
        brd(0, v);  chk("R1 status after master reset", v, 8'h00);
        chk("R1 rts_n high after master reset", rts_n, 1);
        chk("R1 irq_n high after master reset", irq_n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule